// File: doc/BRIEF.md
# Colour LCD Controller Register File

This block is the software-visible register file of a colour panel controller. A processor reaches it through a 32-bit APB-style port. The port has a setup phase and an access phase, and read data is valid during the access phase. The block stores:

- four panel timing words;
- two frame base addresses, one for the upper half of the panel and one for the lower half;
- a control word;
- an interrupt mask and a sticky interrupt status.

A window of palette words sits at byte offsets 0x200 to 0x3FC. A read-only identification window returns one byte per word.

Downstream logic reads several values from the block directly, without going through the bus: the line width in pixels, the panel height in lines, the pixel depth code, the two endian-order flags and the combined enable. Hardware event strobes set status bits. A single interrupt line reports any status bit that is also unmasked. A write to the control word or to a palette word produces a one-cycle pulse, which tells the display pipeline to redraw the frame.

Top module: `lcdc_regfile`

## Requirements
- R1: After a synchronous active-low reset, every stored register reads as zero. `irq_out`, `ctl_enabled` and `refresh_req` are low, `line_pixels` is 16 and `panel_lines` is 1.
- R2: `line_pixels` equals ((timing word 0 AND 0xFC) + 4) * 4. `panel_lines` equals (timing word 1 AND 0x3FF) + 1. Timing word 0 is at byte offset 0x000 and timing word 1 is at 0x004.
- R3: The fields of the control word at offset 0x01C are decoded as follows. `ctl_enabled` is high only when bit 0 (enable) and bit 11 (power) are both 1. `bpp_code` is bits 3:1. `byte_be` is bit 9. `pixel_be` is bit 10.
- R4: The following offsets are read/write and return the last value written: 0x000, 0x004, 0x008 and 0x00C (timing words 0 to 3), 0x010 (upper base), 0x014 (lower base) and 0x01C (control). Offset 0x02C returns the upper base and offset 0x030 returns the lower base.
- R5: A high bit of `irq_evt` sets the matching raw status bit. The bit stays set until it is cleared. The mask is read and written at 0x018, the raw status reads at 0x020, and the masked status (raw AND mask) reads at 0x024.
- R6: A write to 0x028 clears each raw status bit that is written as 1. An event in the same cycle as the write still sets its bit.
- R7: `irq_out` is the OR of all bits of raw status AND mask.
- R8: Offsets 0x200 to 0x3FC read and write the palette words. Word n is at offset 0x200 + 4n.
- R9: Offsets 0xFE0 to 0xFFC, one per word in ascending order, read the bytes 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in the low 8 bits of the data.
- R10: Reads from unmapped offsets and from the write-only clear register at 0x028 return zero. Writes to unmapped offsets, to 0x020, 0x024, 0x02C and 0x030, and to the identification window change no state.
- R11: `refresh_req` is high for the one cycle that follows a write to the control word or to a palette word. It stays low after writes to any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq_evt | input | 4 | Interrupt event strobes, one per status bit |
| irq_out | output | 1 | Interrupt request |
| line_pixels | output | 11 | Pixels per line |
| panel_lines | output | 11 | Lines per panel |
| bpp_code | output | 3 | Pixel depth code |
| byte_be | output | 1 | Big-endian byte order |
| pixel_be | output | 1 | Big-endian pixel order within a byte |
| ctl_enabled | output | 1 | Enable and power both set |
| refresh_req | output | 1 | One-cycle redraw pulse |

## Verification
The assertions check the following on every cycle:

- a control write yields an enable equal to the AND of the written enable and power bits;
- a timing word 1 write yields the matching line count;
- a zero mask silences the interrupt line;
- an asserted interrupt persists while no bus write occurs;
- every redraw pulse follows a control or palette write;
- the first identification word reads 0x10.

The bench scenarios cover the remaining behaviour:

- readback of each storage register;
- decoding of the pixel-count formula, including the boundary values at both ends;
- the conflict between a status clear and an event in the same cycle;
- palette addressing at the two ends of the window;
- the full identification sequence;
- proof that writes to read-only and unmapped offsets leave the state unchanged.

// File: rtl/lcdc_pkg.sv
// Package: shared constants, the address region type and the identification
// byte lookup for the LCD controller register file.
// Assumes byte addressing with 32-bit words; address bits 1:0 are ignored.
package lcdc_pkg;

    // Word indices of the core registers (byte offset / 4).
    localparam logic [6:0] W_TIM0  = 7'd0;
    localparam logic [6:0] W_TIM1  = 7'd1;
    localparam logic [6:0] W_TIM2  = 7'd2;
    localparam logic [6:0] W_TIM3  = 7'd3;
    localparam logic [6:0] W_UBASE = 7'd4;
    localparam logic [6:0] W_LBASE = 7'd5;
    localparam logic [6:0] W_MASK  = 7'd6;
    localparam logic [6:0] W_CTRL  = 7'd7;
    localparam logic [6:0] W_RAW   = 7'd8;
    localparam logic [6:0] W_MSKD  = 7'd9;
    localparam logic [6:0] W_CLR   = 7'd10;
    localparam logic [6:0] W_UCUR  = 7'd11;
    localparam logic [6:0] W_LCUR  = 7'd12;
    localparam int unsigned CORE_WORDS = 13;

    // Control word bit positions.
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_BPP_L = 1;
    localparam int unsigned CB_BYTE  = 9;
    localparam int unsigned CB_PIX   = 10;
    localparam int unsigned CB_PWR   = 11;

    typedef enum logic [1:0] {
        RG_CORE = 2'd0,
        RG_PAL  = 2'd1,
        RG_ID   = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    // Identification byte for slot 0..7 of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] slot);
        case (slot)
            3'd0:    id_byte = 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
// Module: lcdc_addr_decode
// Classifies a bus byte offset into the core register region, the palette
// window, the identification window or unmapped space, and qualifies writes.
// Assumes a 12-bit byte offset; the palette window starts at 0x200 and the
// identification window occupies the top eight words of the 4 KiB page.
module lcdc_addr_decode
    import lcdc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PAL_WORDS = 128
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output region_e           region,
    output logic [6:0]        core_idx,
    output logic [$clog2(PAL_WORDS)-1:0] pal_idx,
    output logic [2:0]        id_slot,
    output logic              wr_access
);
    localparam int unsigned PAL_AW = $clog2(PAL_WORDS);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;

    assign word       = paddr[ADDR_W-1:2];
    assign unused_lsb = ^paddr[1:0];

    // Purpose: extract index fields used by each region.
    assign core_idx  = word[6:0];
    assign pal_idx   = word[PAL_AW-1:0];
    assign id_slot   = word[2:0];
    assign wr_access = psel & penable & pwrite;

    // Purpose: choose the region from the upper word-index bits.
    always_comb begin
        if (word[WORD_W-1:7] == '0 && word[6:0] < 7'(CORE_WORDS)) begin
            region = RG_CORE;
        end else if (word[WORD_W-1:7] == {{(WORD_W-8){1'b0}}, 1'b1} &&
                     {1'b0, word[6:0]} < 8'(PAL_WORDS)) begin
            region = RG_PAL;
        end else if (word[WORD_W-1:3] == '1) begin
            region = RG_ID;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/lcdc_cfg_regs.sv
// Module: lcdc_cfg_regs
// Holds the four timing words, the two frame base addresses and the control
// word, and derives panel geometry and control flags for downstream logic.
// Assumes the write strobe is already qualified by bus access and region.
module lcdc_cfg_regs
    import lcdc_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_TIM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_core,
    input  logic [6:0]        core_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tim_q [NUM_TIM],
    output logic [DATA_W-1:0] ubase_q,
    output logic [DATA_W-1:0] lbase_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [10:0]       line_pixels,
    output logic [10:0]       panel_lines,
    output logic [2:0]        bpp_code,
    output logic              byte_be,
    output logic              pixel_be,
    output logic              ctl_enabled
);

    // Purpose: one storage register per timing word.
    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_q[g] <= '0;
            end else if (wr_core && core_idx == 7'(g)) begin
                tim_q[g] <= wdata;
            end
        end
    end

    // Purpose: frame base and control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ubase_q <= '0;
            lbase_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_core) begin
            if (core_idx == W_UBASE) ubase_q <= wdata;
            if (core_idx == W_LBASE) lbase_q <= wdata;
            if (core_idx == W_CTRL)  ctrl_q  <= wdata;
        end
    end

    // Purpose: geometry derived from the first two timing words.
    assign line_pixels = ({3'b000, tim_q[0][7:2], 2'b00} + 11'd4) << 2;
    assign panel_lines = {1'b0, tim_q[1][9:0]} + 11'd1;

    // Purpose: control field decode.
    assign bpp_code    = ctrl_q[CB_BPP_L+2:CB_BPP_L];
    assign byte_be     = ctrl_q[CB_BYTE];
    assign pixel_be    = ctrl_q[CB_PIX];
    assign ctl_enabled = ctrl_q[CB_EN] & ctrl_q[CB_PWR];

endmodule

// File: rtl/lcdc_irq_regs.sv
// Module: lcdc_irq_regs
// Interrupt mask and sticky raw status with write-one-to-clear, plus the
// combined interrupt line. An event arriving together with a clear of the same
// bit wins, so no event is lost. Assumes events are single-cycle strobes or levels.
module lcdc_irq_regs #(
    parameter int unsigned NUM_IRQ = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask,
    input  logic               wr_clear,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_IRQ-1:0] evt,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic [NUM_IRQ-1:0] raw_q,
    output logic [NUM_IRQ-1:0] masked,
    output logic               irq
);
    logic [NUM_IRQ-1:0] clr_bits;

    assign clr_bits = wr_clear ? wdata[NUM_IRQ-1:0] : '0;

    // Purpose: mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= wdata[NUM_IRQ-1:0];
        end
    end

    // Purpose: sticky status, cleared by writing ones, set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt;
        end
    end

    // Purpose: masked view and interrupt request.
    assign masked = raw_q & mask_q;
    assign irq    = |masked;

endmodule

// File: rtl/lcdc_palette.sv
// Module: lcdc_palette
// Palette word storage with a synchronous write and a combinational read.
// Assumes the index is already range-checked by the decoder.
module lcdc_palette #(
    parameter int unsigned PAL_WORDS = 128,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(PAL_WORDS)-1:0] idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata
);
    logic [DATA_W-1:0] mem [PAL_WORDS];

    // Purpose: clear on reset, otherwise store the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAL_WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Purpose: asynchronous read of the addressed word.
    assign rdata = mem[idx];

endmodule

// File: rtl/lcdc_regfile.sv
// Module: lcdc_regfile (top)
// Register file of a colour LCD controller. It decodes the bus address, routes
// writes to the configuration, interrupt and palette storage, multiplexes read
// data, and raises a one-cycle redraw pulse after control or palette writes.
// Assumes an APB-style bus: writes take effect at the access-phase edge and read
// data is combinational during the access phase.
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_IRQ   = 4,
    parameter int unsigned PAL_WORDS = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    input  logic [NUM_IRQ-1:0] irq_evt,
    output logic               irq_out,
    output logic [10:0]        line_pixels,
    output logic [10:0]        panel_lines,
    output logic [2:0]         bpp_code,
    output logic               byte_be,
    output logic               pixel_be,
    output logic               ctl_enabled,
    output logic               refresh_req
);
    localparam int unsigned PAL_AW  = $clog2(PAL_WORDS);
    localparam int unsigned NUM_TIM = 4;

    region_e            region;
    logic [6:0]         core_idx;
    logic [PAL_AW-1:0]  pal_idx;
    logic [2:0]         id_slot;
    logic               wr_access;
    logic               wr_core, wr_pal;
    logic [DATA_W-1:0]  tim_q [NUM_TIM];
    logic [DATA_W-1:0]  ubase_q, lbase_q, ctrl_q, pal_rdata;
    logic [NUM_IRQ-1:0] mask_q, raw_q, masked;

    lcdc_addr_decode #(.ADDR_W(ADDR_W), .PAL_WORDS(PAL_WORDS)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .region(region), .core_idx(core_idx), .pal_idx(pal_idx),
        .id_slot(id_slot), .wr_access(wr_access)
    );

    assign wr_core = wr_access && region == RG_CORE;
    assign wr_pal  = wr_access && region == RG_PAL;

    lcdc_cfg_regs #(.DATA_W(DATA_W), .NUM_TIM(NUM_TIM)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_core(wr_core), .core_idx(core_idx),
        .wdata(pwdata), .tim_q(tim_q), .ubase_q(ubase_q), .lbase_q(lbase_q),
        .ctrl_q(ctrl_q), .line_pixels(line_pixels), .panel_lines(panel_lines),
        .bpp_code(bpp_code), .byte_be(byte_be), .pixel_be(pixel_be),
        .ctl_enabled(ctl_enabled)
    );

    lcdc_irq_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_mask(wr_core && core_idx == W_MASK),
        .wr_clear(wr_core && core_idx == W_CLR),
        .wdata(pwdata), .evt(irq_evt), .mask_q(mask_q), .raw_q(raw_q),
        .masked(masked), .irq(irq_out)
    );

    lcdc_palette #(.PAL_WORDS(PAL_WORDS), .DATA_W(DATA_W)) u_pal (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_pal), .idx(pal_idx),
        .wdata(pwdata), .rdata(pal_rdata)
    );

    // Purpose: one-cycle redraw pulse after a control or palette write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refresh_req <= 1'b0;
        end else begin
            refresh_req <= wr_pal | (wr_core && core_idx == W_CTRL);
        end
    end

    // Purpose: read-data multiplexer across all regions.
    always_comb begin
        prdata = '0;
        unique case (region)
            RG_CORE: begin
                case (core_idx)
                    W_TIM0, W_TIM1, W_TIM2, W_TIM3:
                             prdata = tim_q[core_idx[1:0]];
                    W_UBASE, W_UCUR: prdata = ubase_q;
                    W_LBASE, W_LCUR: prdata = lbase_q;
                    W_MASK:  prdata = DATA_W'(mask_q);
                    W_CTRL:  prdata = ctrl_q;
                    W_RAW:   prdata = DATA_W'(raw_q);
                    W_MSKD:  prdata = DATA_W'(masked);
                    default: prdata = '0;
                endcase
            end
            RG_PAL:  prdata = pal_rdata;
            RG_ID:   prdata = DATA_W'(id_byte(id_slot));
            default: prdata = '0;
        endcase
    end

endmodule

// File: rtl/lcdc_regfile_chk.sv
// Module: lcdc_regfile_chk
// Checker bound to lcdc_regfile. It relates bus writes, events and outputs
// over time. Assumes the default parameter widths.
module lcdc_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        irq_out,
    input logic        refresh_req,
    input logic        ctl_enabled,
    input logic [10:0] panel_lines
);
    logic wr;
    assign wr = psel & penable & pwrite;

    AST_ENABLE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h01C) |=> ctl_enabled == ($past(pwdata[0]) & $past(pwdata[11]))); // R3

    AST_LINES_FROM_TIM1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h004) |=> panel_lines == {1'b0, $past(pwdata[9:0])} + 11'd1); // R2

    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == 12'h018 && pwdata[3:0] == 4'h0) |=> !irq_out); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !wr) |=> irq_out); // R5

    AST_REFRESH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> ($past(rst_n) && $past(wr) &&
                         ($past(paddr[11:2]) == 10'd7 || $past(paddr[11:9]) == 3'b001))); // R11

    AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == 12'hFE0) |-> prdata == 32'h10); // R9

endmodule

bind lcdc_regfile lcdc_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_out(irq_out),
    .refresh_req(refresh_req), .ctl_enabled(ctl_enabled), .panel_lines(panel_lines)
);

// File: tb/lcdc_regfile_tb.sv
`timescale 1ns/1ps
module lcdc_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [3:0]  irq_evt = '0;
    logic        irq_out, byte_be, pixel_be, ctl_enabled, refresh_req;
    logic [10:0] line_pixels, panel_lines;
    logic [2:0]  bpp_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    sb_item_t cur;

    always #2 clk = ~clk;

    lcdc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_evt(irq_evt),
        .irq_out(irq_out), .line_pixels(line_pixels), .panel_lines(panel_lines),
        .bpp_code(bpp_code), .byte_be(byte_be), .pixel_be(pixel_be),
        .ctl_enabled(ctl_enabled), .refresh_req(refresh_req)
    );

    // Monitor: compares read data in the access phase with the queued expectation.
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL read with empty scoreboard addr=%h actual=%h expected=none", paddr, prdata);
            end else begin
                cur = sb_q.pop_front();
                if (prdata !== cur.exp || paddr !== cur.addr) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", cur.tag, paddr, prdata, cur.exp);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Driver: pushes the expectation, then performs the read.
    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] v);
        @(posedge clk); #1; irq_evt = v;
        @(posedge clk); #1; irq_evt = '0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 irq_out", 32'(irq_out), 32'd0);
        chk("R1 ctl_enabled", 32'(ctl_enabled), 32'd0);
        chk("R1 refresh_req", 32'(refresh_req), 32'd0);
        chk("R1 line_pixels", 32'(line_pixels), 32'd16);
        chk("R1 panel_lines", 32'(panel_lines), 32'd1);
        bus_read(12'h01C, 32'h0, "R1 control reset");
        bus_read(12'h000, 32'h0, "R1 timing0 reset");
        bus_read(12'h210, 32'h0, "R1 palette reset");

        // R2 geometry
        bus_write(12'h000, 32'h0000_00FF);
        chk("R2 pixels max", 32'(line_pixels), 32'd1024);
        bus_write(12'h000, 32'h0000_0013);
        chk("R2 pixels low bits masked", 32'(line_pixels), 32'd80);
        bus_write(12'h004, 32'h0000_07FF);
        chk("R2 lines max", 32'(panel_lines), 32'd1024);
        bus_write(12'h004, 32'h0000_0005);
        chk("R2 lines", 32'(panel_lines), 32'd6);

        // R4 readback
        bus_write(12'h008, 32'hA5A5_0001);
        bus_write(12'h00C, 32'h0000_1234);
        bus_write(12'h010, 32'h8000_1000);
        chk("R11 no pulse on base write", 32'(refresh_req), 32'd0);
        bus_write(12'h014, 32'h0000_2000);
        bus_read(12'h000, 32'h0000_0013, "R4 timing0");
        bus_read(12'h004, 32'h0000_0005, "R4 timing1");
        bus_read(12'h008, 32'hA5A5_0001, "R4 timing2");
        bus_read(12'h00C, 32'h0000_1234, "R4 timing3");
        bus_read(12'h010, 32'h8000_1000, "R4 upper base");
        bus_read(12'h014, 32'h0000_2000, "R4 lower base");
        bus_read(12'h02C, 32'h8000_1000, "R4 upper current");
        bus_read(12'h030, 32'h0000_2000, "R4 lower current");

        // R3 and R11 control decode and pulse
        bus_write(12'h01C, 32'h0000_0001);
        chk("R11 pulse after control write", 32'(refresh_req), 32'd1);
        chk("R3 enable without power", 32'(ctl_enabled), 32'd0);
        @(posedge clk); #1;
        chk("R11 pulse one cycle", 32'(refresh_req), 32'd0);
        bus_write(12'h01C, 32'h0000_0A07);
        chk("R3 enabled", 32'(ctl_enabled), 32'd1);
        chk("R3 bpp", 32'(bpp_code), 32'd3);
        chk("R3 byte_be", 32'(byte_be), 32'd1);
        chk("R3 pixel_be", 32'(pixel_be), 32'd0);
        bus_write(12'h01C, 32'h0000_0C00);
        chk("R3 power without enable", 32'(ctl_enabled), 32'd0);
        chk("R3 pixel_be set", 32'(pixel_be), 32'd1);
        bus_read(12'h01C, 32'h0000_0C00, "R4 control");

        // R5 R6 R7 interrupts
        bus_write(12'h018, 32'h0000_0005);
        pulse_evt(4'b0011);
        repeat (3) @(posedge clk); #1;
        bus_read(12'h020, 32'h3, "R5 raw sticky");
        bus_read(12'h024, 32'h1, "R5 masked");
        bus_read(12'h018, 32'h5, "R5 mask");
        chk("R7 irq high", 32'(irq_out), 32'd1);
        bus_write(12'h028, 32'h0000_0001);
        chk("R7 irq low after clear", 32'(irq_out), 32'd0);
        bus_read(12'h020, 32'h2, "R6 clear bit0");
        irq_evt = 4'b0100;
        bus_write(12'h028, 32'h0000_0004);
        irq_evt = 4'b0000;
        bus_read(12'h020, 32'h6, "R6 event beats clear");
        chk("R7 irq from bit2", 32'(irq_out), 32'd1);
        bus_write(12'h028, 32'h0000_000F);
        bus_read(12'h020, 32'h0, "R6 clear all");
        chk("R7 irq low", 32'(irq_out), 32'd0);

        // R8 palette
        bus_write(12'h200, 32'hDEAD_0001);
        chk("R11 pulse after palette write", 32'(refresh_req), 32'd1);
        bus_write(12'h2A0, 32'h1234_5678);
        bus_write(12'h3FC, 32'hCAFE_007F);
        bus_read(12'h200, 32'hDEAD_0001, "R8 palette first");
        bus_read(12'h2A0, 32'h1234_5678, "R8 palette middle");
        bus_read(12'h3FC, 32'hCAFE_007F, "R8 palette last");

        // R9 identification
        bus_read(12'hFE0, 32'h10, "R9 id0");
        bus_read(12'hFE4, 32'h11, "R9 id1");
        bus_read(12'hFE8, 32'h04, "R9 id2");
        bus_read(12'hFEC, 32'h00, "R9 id3");
        bus_read(12'hFF0, 32'h0D, "R9 id4");
        bus_read(12'hFF4, 32'hF0, "R9 id5");
        bus_read(12'hFF8, 32'h05, "R9 id6");
        bus_read(12'hFFC, 32'hB1, "R9 id7");

        // R10 unmapped and read-only
        bus_write(12'h040, 32'hFFFF_FFFF);
        bus_read(12'h040, 32'h0, "R10 unmapped read");
        bus_write(12'h020, 32'h0000_000F);
        bus_read(12'h020, 32'h0, "R10 raw not writable");
        bus_write(12'h02C, 32'h0000_0055);
        bus_read(12'h02C, 32'h8000_1000, "R10 current not writable");
        bus_read(12'h010, 32'h8000_1000, "R10 base unchanged");
        bus_write(12'hFE0, 32'h0000_00AA);
        bus_read(12'hFE0, 32'h10, "R10 id not writable");
        bus_read(12'h028, 32'h0, "R10 clear reads zero");
        bus_read(12'h400, 32'h0, "R10 above palette");
        bus_read(12'hFDC, 32'h0, "R10 below id");

        repeat (3) @(posedge clk);
        chk("R1 scoreboard drained", 32'(sb_q.size()), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule